// File: doc/BRIEF.md
# Atomic Read-Modify-Write Operation Unit

This unit computes the result of one atomic read-modify-write on a single 64-bit memory word. The memory side supplies the word it currently holds. The requester supplies an operation code, an operand, an optional compare value, an operand size and the low address bits. The unit returns three things: the word to write back, the previous lane value to hand back to the requester, and a flag that says whether the write-back should actually happen.

The unit handles arithmetic and bitwise fetch-and-op, signed and unsigned minimum and maximum, unconditional exchange, and compare-exchange. Each works on a byte, half-word, word or double-word lane within the 64-bit word. Bytes outside the selected lane are copied through untouched, so the caller can always write back the full word. A request is accepted with a valid/ready handshake, and its result is registered and shows up on the next cycle.

Top module: `amo_alu`

## Requirements
- R1: While reset is held and on the first edge after it, rsp_valid and rsp_store are low. From the second clock edge after reset is released, req_ready is high.
- R2: rsp_valid is high in exactly the cycle after a cycle in which req_valid and req_ready are both high, and it is low otherwise.
- R3: req_size selects the lane width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. The lane starts at byte req_addr rounded down to a multiple of the lane width in bytes. Every bit of rsp_wdata outside the lane equals req_mem.
- R4: rsp_old holds the lane as it was before the update, zero-extended to 64 bits, for every operation.
- R5: The low lane-width bits of req_operand are the operand. Code 0 adds, code 1 XORs, code 2 ORs and code 3 ANDs; the add wraps modulo the lane width.
- R6: Code 4 stores the unsigned maximum of lane and operand. Code 6 stores the unsigned minimum.
- R7: Code 5 stores the signed maximum and code 7 the signed minimum. Both lane and operand are sign-extended from the lane's top bit before the comparison.
- R8: Code 8 (exchange) stores the operand into the lane.
- R9: Code 9 (compare-exchange) stores the operand and raises rsp_store when the lane equals the low lane-width bits of req_cmp. Otherwise it writes back req_mem unchanged with rsp_store low.
- R10: Codes 0 to 8 always give rsp_store high. Codes 10 to 15 give rsp_store low and rsp_wdata equal to req_mem.
- R11: rsp_store is low whenever rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 4 | Operation code |
| req_size | input | 2 | Lane width code |
| req_addr | input | 3 | Byte address within the word |
| req_mem | input | 64 | Current memory word |
| req_operand | input | 64 | Operand, right-justified |
| req_cmp | input | 64 | Compare value, right-justified |
| rsp_valid | output | 1 | Result present |
| rsp_wdata | output | 64 | Word to write back |
| rsp_old | output | 64 | Previous lane value, zero-extended |
| rsp_store | output | 1 | Write-back should occur |

## Verification
Every result comes from a single registered stage, so a bad lane offset, mask or comparison shows up at the ports on the cycle right after the handshake. It can appear as changed bytes outside the lane, as stray high bits in rsp_old, or as a store flag that is wrong for the compare outcome. Signed and unsigned comparisons are exercised on lane values whose top bit is set, where the two orderings disagree. A mistake in sign extension or in the variant chosen therefore changes the written lane. Narrow lanes are driven at unaligned addresses, which exposes a wrong rounding of the address.

// File: rtl/amo_pkg.sv
package amo_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_XOR  = 4'd1,
        OP_OR   = 4'd2,
        OP_AND  = 4'd3,
        OP_UMAX = 4'd4,
        OP_SMAX = 4'd5,
        OP_UMIN = 4'd6,
        OP_SMIN = 4'd7,
        OP_SWAP = 4'd8,
        OP_CAS  = 4'd9
    } amo_op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } amo_size_e;
endpackage

// File: rtl/amo_lane_slice.sv
module amo_lane_slice #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = $clog2(DATA_W / 8),
    parameter int SHW    = ADDR_W + 3
) (
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] mem,
    input  logic [DATA_W-1:0] opnd,
    input  logic [DATA_W-1:0] cmp,
    output logic [DATA_W-1:0] mask,
    output logic [SHW-1:0]    shift,
    output logic [DATA_W-1:0] lane_u,
    output logic [DATA_W-1:0] lane_s,
    output logic [DATA_W-1:0] opnd_u,
    output logic [DATA_W-1:0] opnd_s,
    output logic [DATA_W-1:0] cmp_u
);
    import amo_pkg::*;

    logic [ADDR_W-1:0] bytes_m1;
    logic [ADDR_W-1:0] offset;
    logic [DATA_W-1:0] top_bit;

    always_comb begin
        case (amo_size_e'(size))
            SZ_8:    mask = DATA_W'(8'hFF);
            SZ_16:   mask = DATA_W'(16'hFFFF);
            SZ_32:   mask = DATA_W'(32'hFFFF_FFFF);
            default: mask = '1;
        endcase
        bytes_m1 = (ADDR_W'(1) << size) - ADDR_W'(1);
        offset   = addr & ~bytes_m1;
        shift    = {offset, 3'b000};
        top_bit  = mask & ~(mask >> 1);
        lane_u   = (mem >> shift) & mask;
        opnd_u   = opnd & mask;
        cmp_u    = cmp & mask;
        lane_s   = ((lane_u & top_bit) != '0) ? (lane_u | ~mask) : lane_u;
        opnd_s   = ((opnd_u & top_bit) != '0) ? (opnd_u | ~mask) : opnd_u;
    end
endmodule

// File: rtl/amo_op_unit.sv
module amo_op_unit #(
    parameter int DATA_W = 64
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] lane_u,
    input  logic [DATA_W-1:0] lane_s,
    input  logic [DATA_W-1:0] opnd_u,
    input  logic [DATA_W-1:0] opnd_s,
    input  logic [DATA_W-1:0] cmp_u,
    output logic [DATA_W-1:0] result,
    output logic              store
);
    import amo_pkg::*;

    logic lt_u;
    logic lt_s;

    always_comb begin
        lt_u   = lane_u < opnd_u;
        lt_s   = $signed(lane_s) < $signed(opnd_s);
        result = lane_u;
        store  = 1'b1;
        case (amo_op_e'(op))
            OP_ADD:  result = lane_u + opnd_u;
            OP_XOR:  result = lane_u ^ opnd_u;
            OP_OR:   result = lane_u | opnd_u;
            OP_AND:  result = lane_u & opnd_u;
            OP_UMAX: result = lt_u ? opnd_u : lane_u;
            OP_UMIN: result = lt_u ? lane_u : opnd_u;
            OP_SMAX: result = lt_s ? opnd_u : lane_u;
            OP_SMIN: result = lt_s ? lane_u : opnd_u;
            OP_SWAP: result = opnd_u;
            OP_CAS: begin
                store  = (lane_u == cmp_u);
                result = store ? opnd_u : lane_u;
            end
            default: store = 1'b0;
        endcase
    end
endmodule

// File: rtl/amo_lane_merge.sv
module amo_lane_merge #(
    parameter int DATA_W = 64,
    parameter int SHW    = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] mem,
    input  logic [DATA_W-1:0] result,
    input  logic [DATA_W-1:0] mask,
    input  logic [SHW-1:0]    shift,
    output logic [DATA_W-1:0] wdata
);
    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] ins;
    logic [DATA_W-1:0] sel;

    assign ins = (result & mask) << shift;
    assign sel = mask << shift;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign wdata[8*b +: 8] = sel[8*b] ? ins[8*b +: 8] : mem[8*b +: 8];
    end
endmodule

// File: rtl/amo_alu.sv
module amo_alu #(
    parameter int DATA_W = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [3:0]                    req_op,
    input  logic [1:0]                    req_size,
    input  logic [$clog2(DATA_W/8)-1:0]   req_addr,
    input  logic [DATA_W-1:0]             req_mem,
    input  logic [DATA_W-1:0]             req_operand,
    input  logic [DATA_W-1:0]             req_cmp,
    output logic                          rsp_valid,
    output logic [DATA_W-1:0]             rsp_wdata,
    output logic [DATA_W-1:0]             rsp_old,
    output logic                          rsp_store
);
    localparam int ADDR_W = $clog2(DATA_W / 8);
    localparam int SHW    = ADDR_W + 3;

    typedef struct packed {
        logic              ready;
        logic              valid;
        logic              store;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] old;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] mask, lane_u, lane_s, opnd_u, opnd_s, cmp_u;
    logic [DATA_W-1:0] result, merged;
    logic [SHW-1:0]    shift;
    logic              do_store;
    logic              fire;

    amo_lane_slice #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SHW(SHW)) u_slice (
        .size   (req_size),
        .addr   (req_addr),
        .mem    (req_mem),
        .opnd   (req_operand),
        .cmp    (req_cmp),
        .mask   (mask),
        .shift  (shift),
        .lane_u (lane_u),
        .lane_s (lane_s),
        .opnd_u (opnd_u),
        .opnd_s (opnd_s),
        .cmp_u  (cmp_u)
    );

    amo_op_unit #(.DATA_W(DATA_W)) u_op (
        .op     (req_op),
        .lane_u (lane_u),
        .lane_s (lane_s),
        .opnd_u (opnd_u),
        .opnd_s (opnd_s),
        .cmp_u  (cmp_u),
        .result (result),
        .store  (do_store)
    );

    amo_lane_merge #(.DATA_W(DATA_W), .SHW(SHW)) u_merge (
        .mem    (req_mem),
        .result (result),
        .mask   (mask),
        .shift  (shift),
        .wdata  (merged)
    );

    assign fire = req_valid && st_q.ready;

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b1;
        st_d.valid = fire;
        st_d.store = fire && do_store;
        if (fire) begin
            st_d.wdata = merged;
            st_d.old   = lane_u;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = st_q.ready;
    assign rsp_valid = st_q.valid;
    assign rsp_store = st_q.store;
    assign rsp_wdata = st_q.wdata;
    assign rsp_old   = st_q.old;
endmodule

// File: rtl/amo_alu_chk.sv
module amo_alu_chk #(
    parameter int DATA_W = 64
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_ready,
    input logic [3:0]                  req_op,
    input logic [1:0]                  req_size,
    input logic [DATA_W-1:0]           req_mem,
    input logic                        rsp_valid,
    input logic [DATA_W-1:0]           rsp_wdata,
    input logic [DATA_W-1:0]           rsp_old,
    input logic                        rsp_store
);
    logic              fire;
    logic [DATA_W-1:0] width_mask;

    assign fire = req_valid && req_ready;

    always_comb begin
        case (req_size)
            2'd0:    width_mask = DATA_W'(8'hFF);
            2'd1:    width_mask = DATA_W'(16'hFFFF);
            2'd2:    width_mask = DATA_W'(32'hFFFF_FFFF);
            default: width_mask = '1;
        endcase
    end

    a_r2_valid_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> rsp_valid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !rsp_valid);
    a_r11_idle_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_store);
    a_r4_old_fits_lane: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ((rsp_old & ~$past(width_mask)) == '0));
    a_r9_cas_fail_keeps_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_op == 4'd9) |=> (rsp_store || rsp_wdata == $past(req_mem)));
    a_r10_undefined_op: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_op > 4'd9) |=> (!rsp_store && rsp_wdata == $past(req_mem)));
    a_r10_defined_op_stores: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && req_op < 4'd9) |=> rsp_store);
endmodule

bind amo_alu amo_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_size  (req_size),
    .req_mem   (req_mem),
    .rsp_valid (rsp_valid),
    .rsp_wdata (rsp_wdata),
    .rsp_old   (rsp_old),
    .rsp_store (rsp_store)
);

// File: tb/amo_alu_tb.sv
`timescale 1ns/1ps
module amo_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = '0;
    logic [1:0]  req_size = '0;
    logic [2:0]  req_addr = '0;
    logic [63:0] req_mem = '0;
    logic [63:0] req_operand = '0;
    logic [63:0] req_cmp = '0;
    logic        rsp_valid;
    logic [63:0] rsp_wdata;
    logic [63:0] rsp_old;
    logic        rsp_store;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    amo_alu u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_size(req_size), .req_addr(req_addr),
        .req_mem(req_mem), .req_operand(req_operand), .req_cmp(req_cmp),
        .rsp_valid(rsp_valid), .rsp_wdata(rsp_wdata), .rsp_old(rsp_old),
        .rsp_store(rsp_store)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    task automatic model(input logic [3:0] op, input logic [1:0] sz, input logic [2:0] ad,
                         input logic [63:0] mem, input logic [63:0] opd, input logic [63:0] cm,
                         output logic [63:0] w, output logic [63:0] old, output logic st);
        int nb = 1 << sz;
        int off = (ad / nb) * nb;
        logic [63:0] m = (nb == 8) ? '1 : ((64'd1 << (nb * 8)) - 64'd1);
        logic [63:0] lane = (mem >> (off * 8)) & m;
        logic [63:0] a = opd & m;
        logic [63:0] c = cm & m;
        logic [63:0] ls = lane[nb*8-1] ? (lane | ~m) : lane;
        logic [63:0] as = a[nb*8-1] ? (a | ~m) : a;
        logic [63:0] r = lane;
        st = 1'b1;
        case (op)
            4'd0: r = lane + a;
            4'd1: r = lane ^ a;
            4'd2: r = lane | a;
            4'd3: r = lane & a;
            4'd4: r = (lane > a) ? lane : a;
            4'd5: r = ($signed(ls) > $signed(as)) ? lane : a;
            4'd6: r = (lane < a) ? lane : a;
            4'd7: r = ($signed(ls) < $signed(as)) ? lane : a;
            4'd8: r = a;
            4'd9: begin st = (lane == c); r = st ? a : lane; end
            default: st = 1'b0;
        endcase
        w = (mem & ~(m << (off * 8))) | ((r & m) << (off * 8));
        old = lane;
    endtask

    task automatic drive(input logic [3:0] op, input logic [1:0] sz, input logic [2:0] ad,
                         input logic [63:0] mem, input logic [63:0] opd, input logic [63:0] cm);
        req_valid = 1'b1; req_op = op; req_size = sz; req_addr = ad;
        req_mem = mem; req_operand = opd; req_cmp = cm;
    endtask

    task automatic check_rsp(input string req, input logic [3:0] op, input logic [1:0] sz,
                             input logic [2:0] ad, input logic [63:0] mem,
                             input logic [63:0] opd, input logic [63:0] cm);
        logic [63:0] w, o;
        logic s;
        model(op, sz, ad, mem, opd, cm, w, o, s);
        check({req, " valid"}, {63'd0, rsp_valid}, 64'd1);
        check({req, " wdata"}, rsp_wdata, w);
        check({req, " old R4"}, rsp_old, o);
        check({req, " store"}, {63'd0, rsp_store}, {63'd0, s});
    endtask

    task automatic one_req(input string req, input logic [3:0] op, input logic [1:0] sz,
                           input logic [2:0] ad, input logic [63:0] mem,
                           input logic [63:0] opd, input logic [63:0] cm);
        @(negedge clk);
        drive(op, sz, ad, mem, opd, cm);
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(req, op, sz, ad, mem, opd, cm);
    endtask

    task automatic t_reset;
        check("R1 valid in reset", {63'd0, rsp_valid}, 64'd0);
        check("R1 store in reset", {63'd0, rsp_store}, 64'd0);
        check("R1 ready in reset", {63'd0, req_ready}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R1 ready after reset", {63'd0, req_ready}, 64'd1);
        check("R2 idle valid low", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic t_bitwise;
        // hand-computed: byte 3 of 0x...55667788 is 0x55; 0x55+0xC0 wraps to 0x15
        @(negedge clk);
        drive(4'd0, 2'd0, 3'd3, 64'h1122334455667788, 64'hFFFF_FFC0, 64'd0);
        @(negedge clk); req_valid = 1'b0;
        check("R5 add wrap 8b", rsp_wdata, 64'h1122334415667788);
        check("R4 old byte", rsp_old, 64'h55);
        one_req("R5 xor 16b", 4'd1, 2'd1, 3'd2, 64'hDEADBEEFCAFEF00D, 64'h0F0F, 0);
        one_req("R5 or 32b", 4'd2, 2'd2, 3'd4, 64'h00000000FFFFFFFF, 64'h80000001, 0);
        one_req("R5 and 64b", 4'd3, 2'd3, 3'd5, 64'hF0F0F0F0F0F0F0F0, 64'h0FF00FF00FF00FF0, 0);
        one_req("R5 add 64b wrap", 4'd0, 2'd3, 3'd0, 64'hFFFFFFFFFFFFFFFF, 64'd2, 0);
    endtask

    task automatic t_minmax;
        // lane 0x80 vs operand 0x01 at byte 6
        @(negedge clk);
        drive(4'd5, 2'd0, 3'd6, 64'h0080000000000000, 64'h01, 0);
        @(negedge clk); req_valid = 1'b0;
        check("R7 smax picks positive", rsp_wdata, 64'h0001000000000000);
        @(negedge clk);
        drive(4'd4, 2'd0, 3'd6, 64'h0080000000000000, 64'h01, 0);
        @(negedge clk); req_valid = 1'b0;
        check("R6 umax keeps 0x80", rsp_wdata, 64'h0080000000000000);
        one_req("R6 umin 16b", 4'd6, 2'd1, 3'd5, 64'h1234_8000_5678_9ABC, 64'h7FFF, 0);
        one_req("R7 smin 16b", 4'd7, 2'd1, 3'd5, 64'h1234_8000_5678_9ABC, 64'h7FFF, 0);
        one_req("R7 smin 32b", 4'd7, 2'd2, 3'd7, 64'h7FFFFFFF_00000005, 64'hFFFFFFFF, 0);
        one_req("R7 smax 64b", 4'd5, 2'd3, 3'd0, 64'h8000000000000000, 64'd3, 0);
    endtask

    task automatic t_swap_cas;
        one_req("R8 swap 8b", 4'd8, 2'd0, 3'd1, 64'hAAAAAAAAAAAAAAAA, 64'h1234_5642, 0);
        one_req("R3 swap 32b unaligned", 4'd8, 2'd2, 3'd3, 64'h0123456789ABCDEF, 64'hCAFEBABE, 0);
        @(negedge clk);
        drive(4'd9, 2'd1, 3'd6, 64'hBEEF_0000_0000_0000, 64'h1111, 64'hFFFF_BEEF);
        @(negedge clk); req_valid = 1'b0;
        check("R9 cas hit wdata", rsp_wdata, 64'h1111_0000_0000_0000);
        check("R9 cas hit store", {63'd0, rsp_store}, 64'd1);
        @(negedge clk);
        drive(4'd9, 2'd1, 3'd6, 64'hBEEF_0000_0000_0000, 64'h1111, 64'hBEEE);
        @(negedge clk); req_valid = 1'b0;
        check("R9 cas miss wdata", rsp_wdata, 64'hBEEF_0000_0000_0000);
        check("R9 cas miss store", {63'd0, rsp_store}, 64'd0);
        one_req("R9 cas 64b hit", 4'd9, 2'd3, 3'd0, 64'h55, 64'h66, 64'h55);
    endtask

    task automatic t_undefined_and_idle;
        @(negedge clk);
        drive(4'd12, 2'd2, 3'd0, 64'h0102030405060708, 64'hFFFF, 0);
        @(negedge clk); req_valid = 1'b0;
        check("R10 undefined wdata", rsp_wdata, 64'h0102030405060708);
        check("R10 undefined store", {63'd0, rsp_store}, 64'd0);
        @(negedge clk);
        check("R2 valid drops", {63'd0, rsp_valid}, 64'd0);
        check("R11 store low idle", {63'd0, rsp_store}, 64'd0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        drive(4'd0, 2'd0, 3'd7, 64'hFF00000000000000, 64'h01, 0);
        @(negedge clk);
        check_rsp("R2 b2b first", 4'd0, 2'd0, 3'd7, 64'hFF00000000000000, 64'h01, 0);
        drive(4'd9, 2'd2, 3'd0, 64'h0000000100000002, 64'h9, 64'h3);
        @(negedge clk); req_valid = 1'b0;
        check_rsp("R2 b2b second", 4'd9, 2'd2, 3'd0, 64'h0000000100000002, 64'h9, 64'h3);
        @(negedge clk);
        check("R2 b2b then idle", {63'd0, rsp_valid}, 64'd0);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        t_bitwise();
        t_minmax();
        t_swap_cas();
        t_undefined_and_idle();
        t_back_to_back();
        for (int i = 0; i < 16; i++) begin
            one_req("R3 sweep", 4'(i % 10), 2'(i % 4), 3'(i * 3), 64'h8877665544332211 * (i + 1),
                    64'hF0E1D2C3B4A59687 >> i, 64'h0);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule